// File: doc/BRIEF.md
# Multi-Command SPI Transfer Sequencer

This block drives an SPI master through a short programmed list of command steps. Each step holds a 16-bit command word with its own settings: clock phase and polarity, bit-rate prescale, line mode (one, two or four data lines), read direction, word width, bit order, chip-select keep and three delay enables. Each step also holds a transfer length that counts shifter words. A word shifter outside this block pulses `word_done` after every word. The sequencer counts these pulses against the length of the active step. When the step is used up, it moves to the next step, and after the last programmed step it wraps back to step 0.

Software loads the command words, the lengths and a 3-bit sequence length through a single write port. The fields of the active command are decoded and presented to the shifter and to the chip-select logic. The block also reports the index of the active step and gives single-cycle pulses at the end of each step, for a chip-select release and for completion of the whole sequence. The timing of the chip-select negation delay itself belongs to the chip-select logic, which receives the delay enable together with the release pulse.

Top module: `spi_cmd_seq`

## Requirements
- R1: After reset `cmd_ptr` is 0, `step_end`, `cs_drop` and `seq_done` are 0, and the active fields come from an all-zero command word, so `act_word_bits` is 8 and every other field is 0.
- R2: The active command word is decoded as follows: bit 0 gives `act_cpha`, bit 1 gives `act_cpol`, bits 3:2 give `act_prescale`, bit 7 gives `act_keep_cs` and bit 12 gives `act_lsb_first`. Bit 15 gives `act_clk_dly_en`, bit 14 gives `act_neg_dly_en` and bit 13 gives `act_next_dly_en`.
- R3: Bits 6:5 select the line mode: 00 is one line, 01 is two lines, 10 is four lines, and 11 is shown as 00 on `act_lines`. `act_read` equals bit 4 only when `act_lines` is nonzero, and is 0 otherwise.
- R4: Bits 11:8 set the word width on `act_word_bits`: code 1 gives 16, code 2 gives 32, and every other code gives 8.
- R5: A step with length L lasts for max(L,1) `word_done` pulses. On the last of these pulses, `step_end` is high for exactly one cycle, starting in the cycle after that pulse.
- R6: At the end of a step, `cmd_ptr` advances by one, starting in the same cycle as `step_end`. When the step that ends is the last one, `cmd_ptr` returns to 0 and `seq_done` pulses together with `step_end`. Without `word_done`, and without a sequence-length write, `cmd_ptr` does not change.
- R7: `cs_drop` pulses together with `step_end` when bit 7 (keep) of the step that just ended is clear, and stays low when that bit is set.
- R8: A write to the sequence length returns `cmd_ptr` and the word count to 0 in the next cycle. It takes priority over a `word_done` in the same cycle, and no pulse results from that `word_done`.
- R9: The write port decodes `wr_sel` as 0 for a command word (`wr_data[15:0]`), 1 for a length (`wr_data[LEN_W-1:0]`) and 2 for the sequence length (`wr_data[2:0]`). Code 3 does nothing. Command and length writes whose `wr_idx` is NUM_CMDS or more are ignored.
- R10: The last step index is the sequence-length value, capped at NUM_CMDS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 length, 2 sequence length |
| wr_idx | input | 3 | Step index for command and length writes |
| wr_data | input | 32 | Write data |
| word_done | input | 1 | One-cycle pulse from the shifter after each word |
| act_cpha | output | 1 | Active clock phase |
| act_cpol | output | 1 | Active clock polarity |
| act_prescale | output | 2 | Active bit-rate prescale |
| act_read | output | 1 | Active read direction (two- or four-line modes only) |
| act_lines | output | 2 | Active line mode: 0 one, 1 two, 2 four |
| act_keep_cs | output | 1 | Active chip-select keep flag |
| act_word_bits | output | 6 | Active word width in bits |
| act_lsb_first | output | 1 | Active LSB-first order |
| act_clk_dly_en | output | 1 | Active clock delay enable |
| act_neg_dly_en | output | 1 | Active chip-select negation delay enable |
| act_next_dly_en | output | 1 | Active next-access delay enable |
| cmd_ptr | output | 3 | Index of the active step |
| step_end | output | 1 | One-cycle pulse when a step ends |
| cs_drop | output | 1 | One-cycle pulse asking for chip-select release |
| seq_done | output | 1 | One-cycle pulse when the last step ends |

## Verification
The hardest case to reach is a sequence-length write that arrives in the same cycle as a `word_done` partway through a step with more than one word. Both the pointer and the word count must restart, and no pulse may escape. The bench reaches this case by first partly draining a step of three words, then driving the write and the word pulse on the same edge. After that it checks that a full three pulses are again needed to end the step. A sweep over all eight sequence-length values also runs past the cap at NUM_CMDS-1. During that sweep, garbage is written to the indices that do not exist, so any aliasing would show up on the active fields.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int LEN_MAX_W = 32;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_SEQ  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic       clk_dly_en;
    logic       neg_dly_en;
    logic       next_dly_en;
    logic       lsb_first;
    logic [3:0] width_code;
    logic       keep_cs;
    logic [1:0] lines;
    logic       read;
    logic [1:0] prescale;
    logic       cpol;
    logic       cpha;
  } cmd_word_t;

  // Width code to bit count; unlisted codes fall back to 8.
  function automatic logic [5:0] width_bits(logic [3:0] code);
    case (code)
      4'd1:    return 6'd16;
      4'd2:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

  // The reserved line mode is treated as one line.
  function automatic logic [1:0] lane_mode(logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : m;
  endfunction

  // True when the word now being counted is the final one of its step.
  function automatic logic step_is_last(logic [LEN_MAX_W-1:0] cnt,
                                        logic [LEN_MAX_W-1:0] len);
    if (len == '0) return 1'b1;
    return cnt >= (len - 1'b1);
  endfunction

  // Last step index: requested value, capped at n-1.
  function automatic logic [2:0] clamp_last(logic [2:0] req, int unsigned n);
    if (32'(req) > (n - 1)) return 3'(n - 1);
    return req;
  endfunction

endpackage

// File: rtl/seq_cmd_store.sv
module seq_cmd_store
  import spi_seq_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter int LEN_W    = 32,
  localparam int IDX_W   = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [2:0]       wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output cmd_word_t        rd_cmd,
  output logic [LEN_W-1:0] rd_len
);

  cmd_word_t        cmd_arr [NUM_CMDS];
  logic [LEN_W-1:0] len_arr [NUM_CMDS];

  for (genvar i = 0; i < NUM_CMDS; i++) begin : g_entry
    cmd_word_t        cmd_r;
    logic [LEN_W-1:0] len_r;
    logic             hit;

    assign hit = wr_en && (wr_idx == 3'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_r <= '0;
        len_r <= '0;
      end else if (hit) begin
        if (wr_sel == SEL_CMD) cmd_r <= cmd_word_t'(wr_data[15:0]);
        if (wr_sel == SEL_LEN) len_r <= wr_data[LEN_W-1:0];
      end
    end

    assign cmd_arr[i] = cmd_r;
    assign len_arr[i] = len_r;
  end

  assign rd_cmd = cmd_arr[rd_idx];
  assign rd_len = len_arr[rd_idx];

endmodule

// File: rtl/seq_word_ctr.sv
module seq_word_ctr
  import spi_seq_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             word_done,
  input  logic [LEN_W-1:0] step_len,
  output logic             last_word
);

  logic [LEN_W-1:0] cnt_q;

  assign last_word = step_is_last(LEN_MAX_W'(cnt_q), LEN_MAX_W'(step_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr)       cnt_q <= '0;
    else if (word_done) cnt_q <= last_word ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/seq_ptr_ctl.sv
module seq_ptr_ctl #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             advance,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] ptr,
  output logic             wrap
);

  assign wrap = advance && (ptr == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clr)     ptr <= '0;
    else if (advance) ptr <= wrap ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CMDS = 4,
  parameter int LEN_W    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        word_done,
  output logic        act_cpha,
  output logic        act_cpol,
  output logic [1:0]  act_prescale,
  output logic        act_read,
  output logic [1:0]  act_lines,
  output logic        act_keep_cs,
  output logic [5:0]  act_word_bits,
  output logic        act_lsb_first,
  output logic        act_clk_dly_en,
  output logic        act_neg_dly_en,
  output logic        act_next_dly_en,
  output logic [2:0]  cmd_ptr,
  output logic        step_end,
  output logic        cs_drop,
  output logic        seq_done
);

  localparam int IDX_W = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1;

  // Named internal events
  logic             seq_wr;
  logic [2:0]       seq_q;
  logic [2:0]       seq_last_w;
  logic [IDX_W-1:0] ptr_w;
  cmd_word_t        cur_cmd;
  logic [LEN_W-1:0] cur_len;
  logic             last_word_w;
  logic             step_fin_w;
  logic             wrap_w;
  logic             step_end_q, cs_drop_q, seq_done_q;

  assign seq_wr     = wr_en && (wr_sel == SEL_SEQ);
  assign seq_last_w = clamp_last(seq_q, NUM_CMDS);
  assign step_fin_w = word_done && last_word_w && !seq_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= '0;
    else if (seq_wr) seq_q <= wr_data[2:0];
  end

  seq_cmd_store #(.NUM_CMDS(NUM_CMDS), .LEN_W(LEN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (ptr_w),
    .rd_cmd  (cur_cmd),
    .rd_len  (cur_len)
  );

  seq_word_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (seq_wr),
    .word_done (word_done),
    .step_len  (cur_len),
    .last_word (last_word_w)
  );

  seq_ptr_ctl #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (seq_wr),
    .advance  (step_fin_w),
    .last_idx (IDX_W'(seq_last_w)),
    .ptr      (ptr_w),
    .wrap     (wrap_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_end_q <= 1'b0;
      cs_drop_q  <= 1'b0;
      seq_done_q <= 1'b0;
    end else begin
      step_end_q <= step_fin_w;
      cs_drop_q  <= step_fin_w && !cur_cmd.keep_cs;
      seq_done_q <= wrap_w;
    end
  end

  // Active field decode
  assign act_cpha        = cur_cmd.cpha;
  assign act_cpol        = cur_cmd.cpol;
  assign act_prescale    = cur_cmd.prescale;
  assign act_lines       = lane_mode(cur_cmd.lines);
  assign act_read        = cur_cmd.read && (lane_mode(cur_cmd.lines) != 2'b00);
  assign act_keep_cs     = cur_cmd.keep_cs;
  assign act_word_bits   = width_bits(cur_cmd.width_code);
  assign act_lsb_first   = cur_cmd.lsb_first;
  assign act_clk_dly_en  = cur_cmd.clk_dly_en;
  assign act_neg_dly_en  = cur_cmd.neg_dly_en;
  assign act_next_dly_en = cur_cmd.next_dly_en;

  assign cmd_ptr  = 3'(ptr_w);
  assign step_end = step_end_q;
  assign cs_drop  = cs_drop_q;
  assign seq_done = seq_done_q;

endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       word_done,
  input logic [2:0] cmd_ptr,
  input logic [2:0] seq_last,
  input logic       step_end,
  input logic       cs_drop,
  input logic       seq_done,
  input logic       act_read,
  input logic [1:0] act_lines
);

  // R6 / R10: pointer never passes the capped last index
  a_r10_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr <= seq_last);

  // R6: sequence completion always lands on step 0
  a_r6_done_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (cmd_ptr == 3'd0));

  // R6: completion is a step end
  a_r6_done_is_step: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> step_end);

  // R6: pointer holds without a word pulse or sequence write
  a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_done && !(wr_en && wr_sel == 2'd2)) |=> $stable(cmd_ptr));

  // R7: chip-select release only at a step end
  a_r7_drop_is_step: assert property (@(posedge clk) disable iff (!rst_n)
    cs_drop |-> step_end);

  // R5: step end follows a word pulse
  a_r5_end_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |-> $past(word_done));

  // R8: sequence write clears the pointer and suppresses pulses
  a_r8_seq_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> (cmd_ptr == 3'd0 && !step_end));

  // R3: read direction only with two or four lines
  a_r3_read_needs_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    act_read |-> (act_lines != 2'b00));

endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .word_done (word_done),
  .cmd_ptr   (cmd_ptr),
  .seq_last  (seq_last_w),
  .step_end  (step_end),
  .cs_drop   (cs_drop),
  .seq_done  (seq_done),
  .act_read  (act_read),
  .act_lines (act_lines)
);

// File: tb/spi_cmd_seq_tb.sv
`timescale 1ns/1ps
module spi_cmd_seq_tb;

  localparam int NCMD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [2:0]  wr_idx = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        word_done = 1'b0;
  logic        act_cpha, act_cpol, act_read, act_keep_cs, act_lsb_first;
  logic        act_clk_dly_en, act_neg_dly_en, act_next_dly_en;
  logic [1:0]  act_prescale, act_lines;
  logic [5:0]  act_word_bits;
  logic [2:0]  cmd_ptr;
  logic        step_end, cs_drop, seq_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_seq #(.NUM_CMDS(NCMD), .LEN_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .word_done(word_done),
    .act_cpha(act_cpha), .act_cpol(act_cpol), .act_prescale(act_prescale),
    .act_read(act_read), .act_lines(act_lines), .act_keep_cs(act_keep_cs),
    .act_word_bits(act_word_bits), .act_lsb_first(act_lsb_first),
    .act_clk_dly_en(act_clk_dly_en), .act_neg_dly_en(act_neg_dly_en),
    .act_next_dly_en(act_next_dly_en), .cmd_ptr(cmd_ptr),
    .step_end(step_end), .cs_drop(cs_drop), .seq_done(seq_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic pulse();
    @(negedge clk);
    word_done = 1'b1;
    @(negedge clk);
    word_done = 1'b0;
  endtask

  function automatic logic [5:0] exp_bits(logic [15:0] c);
    logic [3:0] code = c[11:8];
    return (code == 4'd1 || code == 4'd2) ? 6'(8 << code) : 6'd8;
  endfunction

  function automatic logic [1:0] exp_lines(logic [15:0] c);
    return (c[6] & c[5]) ? 2'b00 : c[6:5];
  endfunction

  task automatic check_fields(input logic [15:0] c);
    logic [7:0] a2, e2;
    a2 = {act_clk_dly_en, act_neg_dly_en, act_next_dly_en, act_lsb_first,
          act_keep_cs, act_prescale, act_cpol};
    e2 = {c[15], c[14], c[13], c[12], c[7], c[3:2], c[1]};
    chk(a2 == e2 && act_cpha == c[0], "R2 fields", {23'd0, a2, act_cpha}, {23'd0, e2, c[0]});
    chk(act_lines == exp_lines(c) && act_read == (c[4] && exp_lines(c) != 2'b00),
        "R3 line mode", {29'd0, act_lines, act_read},
        {29'd0, exp_lines(c), c[4] && exp_lines(c) != 2'b00});
    chk(act_word_bits == exp_bits(c), "R4 width", 32'(act_word_bits), 32'(exp_bits(c)));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] cmds [NCMD];
    logic [31:0] lens [NCMD];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_ptr == 3'd0 && !step_end && !cs_drop && !seq_done, "R1 ptr/pulses",
        {28'd0, cmd_ptr, step_end}, 32'd0);
    check_fields(16'h0000);

    // R2 R3 R4: field sweep, including all width and line codes
    for (int k = 0; k < 300; k++) begin
      logic [15:0] c;
      c = 16'(k * 211) ^ 16'(k << 8) ^ 16'(k << 4);
      wr(2'd0, 3'd0, {16'd0, c});
      wr(2'd2, 3'd0, 32'd0);
      check_fields(c);
    end

    // R5 R6 R7 R9 R10: sweep all sequence-length values
    for (int s = 0; s < 8; s++) begin
      int ep, ec, last;
      for (int i = 0; i < NCMD; i++) begin
        cmds[i] = {4'b0000, 4'(i % 3), 1'(i[0] ^ s[0]), 3'b000, 2'(i), 2'b00};
        lens[i] = 32'((i * 3 + s) % 5);
        wr(2'd0, 3'(i), {16'd0, cmds[i]});
        wr(2'd1, 3'(i), lens[i]);
      end
      for (int i = NCMD; i < 8; i++) begin
        wr(2'd0, 3'(i), 32'h0000_FFFF);
        wr(2'd1, 3'(i), 32'd0);
      end
      wr(2'd3, 3'd0, 32'h0000_FFFF); // R9: code 3 writes nothing
      wr(2'd2, 3'd0, 32'(s));
      ep = 0; ec = 0;
      last = (s > NCMD - 1) ? NCMD - 1 : s;
      for (int p = 0; p < 40; p++) begin
        int words;
        bit e_end, e_drop, e_done;
        words = (lens[ep] == 0) ? 1 : int'(lens[ep]);
        e_end = 0; e_drop = 0; e_done = 0;
        ec++;
        if (ec == words) begin
          e_end = 1; e_drop = !cmds[ep][7]; e_done = (ep == last);
          ep = e_done ? 0 : ep + 1; ec = 0;
        end
        pulse();
        chk(step_end == e_end, "R5 step_end", 32'(step_end), 32'(e_end));
        chk(cmd_ptr == 3'(ep), "R6 ptr/R10 cap", 32'(cmd_ptr), 32'(ep));
        chk(seq_done == e_done, "R6 seq_done", 32'(seq_done), 32'(e_done));
        chk(cs_drop == e_drop, "R7 cs_drop", 32'(cs_drop), 32'(e_drop));
        chk(act_prescale == cmds[ep][3:2] && act_keep_cs == cmds[ep][7] &&
            act_word_bits == exp_bits(cmds[ep]), "R9 no alias",
            {24'd0, act_word_bits, act_prescale}, {24'd0, exp_bits(cmds[ep]), cmds[ep][3:2]});
      end
    end

    // R5: long step, pulse lasts one cycle
    wr(2'd1, 3'd0, 32'd150);
    wr(2'd2, 3'd0, 32'd0);
    for (int p = 1; p < 150; p++) begin
      pulse();
      if (step_end) chk(1'b0, "R5 early end", 32'(p), 32'd150);
    end
    n_chk++;
    pulse();
    chk(step_end && seq_done && cmd_ptr == 3'd0, "R5 long step",
        {29'd0, step_end, seq_done, 1'b0}, 32'd6);
    @(negedge clk);
    chk(!step_end, "R5 single cycle", 32'(step_end), 32'd0);

    // R8: sequence write wins over word pulse mid-step
    wr(2'd1, 3'd0, 32'd3);
    wr(2'd1, 3'd1, 32'd0);
    wr(2'd2, 3'd0, 32'd1);
    pulse(); pulse();
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd1; word_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; word_done = 1'b0;
    chk(!step_end && !cs_drop && !seq_done && cmd_ptr == 3'd0, "R8 priority",
        {28'd0, cmd_ptr, step_end}, 32'd0);
    pulse(); pulse();
    chk(!step_end && cmd_ptr == 3'd0, "R8 count cleared", {28'd0, cmd_ptr, step_end}, 32'd0);
    pulse();
    chk(step_end && cmd_ptr == 3'd1, "R8 restart end", {28'd0, cmd_ptr, step_end}, 32'd3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule